// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block decouples code fetch from execution. A fetch engine reads code bytes one at a time from a simple request/response memory port, using a 20-bit physical address built from a 16-bit code segment and a 16-bit instruction offset. It places each returned byte into a six-entry byte queue. The execution side reads the oldest byte from the head of the queue and pops it when consumed. Fetching goes on whenever the queue has room, no read is outstanding and the execution unit is not claiming the bus, so code arrives while the execution unit is busy with earlier work.

A control transfer is signalled by a jump request carrying a new segment and offset. It empties the queue at once and reloads the fetch pointer. Fetching then restarts at the target. If a read is still outstanding when the jump arrives, the byte it returns is thrown away and never reaches the queue.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is high and in the first cycle after it, the queue is empty (`ex_valid` low) and the fetch pointer equals segment 16'hFFFF, offset 16'h0000. The first request therefore uses address 20'hFFFF0.
- R2: `mem_req_addr` equals (segment × 16 + offset) modulo 2^20. For example, segment FFFF and offset FFFF give 20'h0FFEF.
- R3: `mem_req_valid` is high exactly when all of these hold: no read is outstanding, fewer than 6 bytes are queued, `eu_bus_busy` is low and `jump_req` is low. At most one read is outstanding at a time.
- R4: Each accepted request (`mem_req_valid` and `mem_req_ready` both high) advances the offset by one, wrapping at 16 bits. The segment stays unchanged.
- R5: Each byte returned with `mem_rsp_valid` for a live read is appended to the tail of the queue. `ex_byte` shows the oldest queued byte, so bytes leave in fetch order. The queue holds at most 6 bytes.
- R6: `ex_valid` is low whenever the queue is empty. A pop while `ex_valid` is low has no effect: no byte is lost or duplicated.
- R7: A jump request empties the queue in the same cycle and takes priority over any pop or fill in that cycle. The next request uses the jump target.
- R8: A read that is still outstanding when a jump arrives returns a byte that is discarded. No new request starts until that response has come back.
- R9: While `eu_bus_busy` is high, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jump_req | input | 1 | Control transfer: flush and reload fetch pointer |
| jump_seg | input | 16 | Target code segment |
| jump_off | input | 16 | Target offset |
| eu_bus_busy | input | 1 | Execution unit owns the bus this cycle |
| ex_pop | input | 1 | Execution side consumes the head byte |
| ex_valid | output | 1 | Queue holds at least one byte |
| ex_byte | output | 8 | Oldest queued byte |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 20 | Physical byte address of the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |

## Verification
The bench first fills the queue with no pops and a one-cycle memory. This shows that requests stop at six bytes and that the offset advances once per accepted read. It then drains the queue past empty while the execution unit holds the bus. That separates ignored empty pops from lost or repeated bytes, and it shows that the bus claim blocks fetch. Directed jumps, one with a slow read in flight and one to segment FFFF offset FFFF, tell apart discarding a stale byte from keeping it, and a 20-bit wrap from a 21-bit sum. A long random phase with mixed pops, bus claims, ready stalls, response latencies and jumps that coincide with pops and fills is compared cycle by cycle against a behavioural queue model.

// File: rtl/prefetch_queue_pkg.sv
package prefetch_queue_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int PADR_W = 20;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
    } far_ptr_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_DROP = 2'd2
    } fetch_state_e;

    function automatic logic [PADR_W-1:0] phys_addr(far_ptr_t p);
        logic [PADR_W-1:0] base;
        base = {p.seg, 4'h0};
        return base + PADR_W'(p.off);
    endfunction

endpackage

// File: rtl/prefetch_queue_store.sv
module prefetch_queue_store #(
    parameter int DEPTH = 6,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic             head_valid,
    output logic [W-1:0]     head_data,
    output logic             has_room,
    output logic [LVL_W-1:0] level
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             do_pop, do_push;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_valid = (level != '0);
    assign head_data  = slots[rd_ptr];
    assign has_room   = (level != FULL);
    assign do_pop     = pop && head_valid;
    assign do_push    = push && (has_room || do_pop);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

endmodule

// File: rtl/prefetch_queue_fetch.sv
module prefetch_queue_fetch
    import prefetch_queue_pkg::*;
#(
    parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
    parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              jump_req,
    input  far_ptr_t          jump_ptr,
    input  logic              bus_busy,
    input  logic              slot_free,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [PADR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              push,
    output logic [BYTE_W-1:0] push_data,
    output logic [OFF_W-1:0]  cur_off
);

    far_ptr_t     ptr;
    fetch_state_e state;
    logic         fire;

    assign req_valid = (state == FS_IDLE) && slot_free && !bus_busy && !jump_req;
    assign fire      = req_valid && req_ready;
    assign req_addr  = phys_addr(ptr);
    assign push      = rsp_valid && (state == FS_WAIT) && !jump_req;
    assign push_data = rsp_data;
    assign cur_off   = ptr.off;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr.seg <= RESET_SEG;
            ptr.off <= RESET_OFF;
            state   <= FS_IDLE;
        end else begin
            if (jump_req) begin
                ptr <= jump_ptr;
            end else if (fire) begin
                ptr.off <= ptr.off + OFF_W'(1);
            end
            case (state)
                FS_IDLE: if (fire) state <= FS_WAIT;
                FS_WAIT: begin
                    if (rsp_valid)     state <= FS_IDLE;
                    else if (jump_req) state <= FS_DROP;
                end
                FS_DROP: if (rsp_valid) state <= FS_IDLE;
                default: state <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import prefetch_queue_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter logic [15:0] RESET_SEG = 16'hFFFF,
    parameter logic [15:0] RESET_OFF = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        jump_req,
    input  logic [15:0] jump_seg,
    input  logic [15:0] jump_off,
    input  logic        eu_bus_busy,
    input  logic        ex_pop,
    output logic        ex_valid,
    output logic [7:0]  ex_byte,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [19:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [7:0]  mem_rsp_data
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    far_ptr_t          target;
    logic              slot_free;
    logic              fill;
    logic [BYTE_W-1:0] fill_byte;
    logic [LVL_W-1:0]  q_level;
    logic [OFF_W-1:0]  cur_off;

    assign target.seg = jump_seg;
    assign target.off = jump_off;

    prefetch_queue_fetch #(
        .RESET_SEG (RESET_SEG),
        .RESET_OFF (RESET_OFF)
    ) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .jump_req  (jump_req),
        .jump_ptr  (target),
        .bus_busy  (eu_bus_busy),
        .slot_free (slot_free),
        .req_valid (mem_req_valid),
        .req_ready (mem_req_ready),
        .req_addr  (mem_req_addr),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .push      (fill),
        .push_data (fill_byte),
        .cur_off   (cur_off)
    );

    prefetch_queue_store #(
        .DEPTH (DEPTH),
        .W     (BYTE_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (jump_req),
        .push       (fill),
        .push_data  (fill_byte),
        .pop        (ex_pop),
        .head_valid (ex_valid),
        .head_data  (ex_byte),
        .has_room   (slot_free),
        .level      (q_level)
    );

endmodule

// File: rtl/prefetch_queue_checker.sv
module prefetch_queue_checker #(
    parameter int DEPTH = 6,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             jump_req,
    input logic             eu_bus_busy,
    input logic             ex_pop,
    input logic             ex_valid,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [19:0]      mem_req_addr,
    input logic             mem_rsp_valid,
    input logic [LVL_W-1:0] q_level,
    input logic [15:0]      cur_off
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        q_level <= LVL_W'(DEPTH)); // R5

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R3

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        eu_bus_busy |-> !mem_req_valid); // R9

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready && !jump_req) |=> $stable(mem_req_addr)); // R4

    AST_OFF_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> (cur_off == $past(cur_off) + 16'd1)); // R4

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        jump_req |=> !ex_valid); // R7

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (!ex_valid && ex_pop && !mem_rsp_valid) |=> !ex_valid); // R6

endmodule

bind prefetch_queue prefetch_queue_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .jump_req      (jump_req),
    .eu_bus_busy   (eu_bus_busy),
    .ex_pop        (ex_pop),
    .ex_valid      (ex_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .q_level       (q_level),
    .cur_off       (cur_off)
);

// File: tb/prefetch_queue_test.sv
`timescale 1ns/1ps
module prefetch_queue_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        jump_req = 1'b0;
    logic [15:0] jump_seg = '0;
    logic [15:0] jump_off = '0;
    logic        eu_bus_busy = 1'b0;
    logic        ex_pop = 1'b0;
    logic        ex_valid;
    logic [7:0]  ex_byte;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [19:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;

    always #2 clk = ~clk;

    prefetch_queue uut (
        .clk(clk), .rst(rst), .jump_req(jump_req), .jump_seg(jump_seg),
        .jump_off(jump_off), .eu_bus_busy(eu_bus_busy), .ex_pop(ex_pop),
        .ex_valid(ex_valid), .ex_byte(ex_byte), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // stimulus knobs
    bit        b_pop, b_busy, b_jump, b_ready;
    bit [15:0] b_jseg, b_joff;
    int        lat_cfg = 1;

    // memory responder state
    bit        m_busy = 0;
    int        m_cnt = 0;
    bit [19:0] m_addr = '0;

    // reference model state
    logic [7:0] mq[$];
    bit [15:0]  r_seg = 16'hFFFF;
    bit [15:0]  r_off = 16'h0000;
    bit         r_pend = 0;
    bit         r_drop = 0;

    function automatic logic [7:0] mem_byte(logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
    endfunction

    function automatic logic [19:0] addr_of(bit [15:0] s, bit [15:0] o);
        return 20'({s, 4'h0} + {4'h0, o});
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        bit exp_req, fire_d, rv;
        logic [7:0] rd;
        @(negedge clk);
        jump_req      = b_jump;
        jump_seg      = b_jseg;
        jump_off      = b_joff;
        eu_bus_busy   = b_busy;
        ex_pop        = b_pop;
        mem_req_ready = b_ready;
        rv            = m_busy && (m_cnt == 0);
        rd            = mem_byte(m_addr);
        mem_rsp_valid = rv;
        mem_rsp_data  = rd;
        #1;
        exp_req = !r_pend && (mq.size() < 6) && !b_busy && !b_jump;
        check("R6 ex_valid", 32'(ex_valid), 32'(mq.size() > 0));
        if (mq.size() > 0) check("R5 ex_byte", 32'(ex_byte), 32'(mq[0]));
        check("R3 mem_req_valid", 32'(mem_req_valid), 32'(exp_req));
        if (exp_req) check("R2 mem_req_addr", 32'(mem_req_addr), 32'(addr_of(r_seg, r_off)));
        // memory responder
        fire_d = mem_req_valid && mem_req_ready;
        if (rv) m_busy = 0;
        else if (m_busy) m_cnt--;
        if (fire_d) begin
            m_busy = 1;
            m_cnt  = lat_cfg - 1;
            m_addr = mem_req_addr;
        end
        // reference model
        if (b_jump) begin
            mq.delete();
        end else begin
            if (b_pop && mq.size() > 0) void'(mq.pop_front());
            if (rv && r_pend && !r_drop) mq.push_back(rd);
        end
        if (rv && r_pend) begin
            r_pend = 0;
            r_drop = 0;
        end
        if (exp_req && b_ready) begin
            r_pend = 1;
            r_off  = r_off + 16'd1;
        end
        if (b_jump) begin
            r_seg = b_jseg;
            r_off = b_joff;
            if (r_pend) r_drop = 1;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        b_pop = 0; b_busy = 0; b_jump = 0; b_ready = 0; b_jseg = 0; b_joff = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 ex_valid", 32'(ex_valid), 0);
        check("R1 mem_req_valid", 32'(mem_req_valid), 1);
        check("R1 mem_req_addr", 32'(mem_req_addr), 32'h000FFFF0);

        // fill with no pops
        b_ready = 1; lat_cfg = 1;
        run(30);
        check("R5 full stops fetch", 32'(mem_req_valid), 0);
        check("R5 head is first byte", 32'(ex_byte), 32'(mem_byte(20'hFFFF0)));

        // R4: one pop frees a slot, next address is start plus six
        b_pop = 1; step(); b_pop = 0; step();
        check("R4 next request valid", 32'(mem_req_valid), 1);
        check("R4 next address", 32'(mem_req_addr), 32'h000FFFF6);

        // drain past empty with bus claimed
        b_busy = 1; b_pop = 1;
        run(12);
        check("R6 empty after drain", 32'(ex_valid), 0);
        check("R9 busy blocks fetch", 32'(mem_req_valid), 0);
        b_busy = 0; b_pop = 0;
        run(10);
        check("R6 no loss after empty pops", 32'(ex_byte), 32'(mem_byte(20'hFFFF7)));

        // R8: jump while a slow read is in flight
        lat_cfg = 3;
        b_jump = 1; b_jseg = 16'h2000; b_joff = 16'h0000; step();
        b_jump = 0; step();
        step();
        b_jump = 1; b_jseg = 16'h1234; b_joff = 16'h0010; step();
        b_jump = 0;
        check("R7 flushed on jump", 32'(ex_valid), 0);
        run(20);
        check("R8 stale byte discarded", 32'(ex_byte), 32'(mem_byte(20'h12350)));

        // R2: address wrap at 20 bits
        lat_cfg = 1;
        b_jump = 1; b_jseg = 16'hFFFF; b_joff = 16'hFFFF; step();
        b_jump = 0; step();
        check("R7 empty after jump", 32'(ex_valid), 0);
        check("R2 wrap address", 32'(mem_req_addr), 32'h00FFEF);
        run(10);

        // random mix
        for (int i = 0; i < 5000; i++) begin
            b_pop   = ($urandom_range(0, 1) == 1);
            b_busy  = ($urandom_range(0, 4) == 0);
            b_jump  = ($urandom_range(0, 29) == 0);
            b_ready = ($urandom_range(0, 9) < 7);
            b_jseg  = 16'($urandom);
            b_joff  = 16'($urandom);
            lat_cfg = $urandom_range(1, 4);
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule